// File: doc/BRIEF.md
# OTP Security Register Bank

This block holds a 128-bit one-time-programmable security register made of eight 16-bit words. The words are split into two halves. The lower half carries a factory identity value. That value is fixed at build time and can never be written. The upper half belongs to the user. Its bits can be cleared by program commands until a one-way lock seals it.

An upstream command decoder talks to the block through a strobe, a 2-bit opcode, a word address and a 16-bit data word. The block answers reads and lock-status queries one cycle later on a registered read port. A program command aimed at the factory half raises a one-cycle error pulse.

There are two resets. The cold reset (`por_n`) models first power-up: it clears the user half to all ones and unlocks it. The warm reset (`rst_n`) restores the factory words and clears the output registers. It leaves the user words and the lock exactly as they were, in the way non-volatile cells would behave. At power-up both resets are asserted together.

Top module: `otp_sec_regbank`

## Requirements
- R1: After reset, word addresses 0x081..0x084 read the factory value, with word k (address 0x081+k) equal to bits [16k+15:16k] of `FACTORY_INIT`.
- R2: After a cold reset (`por_n` low), user words at 0x085..0x088 read 0xFFFF and the user half is unlocked.
- R3: A read command (opcode 0) with `id_mode` high returns the addressed word on `rd_data` with `rd_valid` high in the cycle after the strobe. `rd_valid` is low in every cycle not preceded by a read or status command.
- R4: A read command issued while `id_mode` is low returns 0xFFFF for every address.
- R5: An address outside 0x081..0x088, including any address with a nonzero bit above bit 7, reads as 0xFFFF. A program to such an address changes no word and raises no error.
- R6: A program command (opcode 1) to an unlocked user word stores old AND data, so stored bits can only go from 1 to 0.
- R7: A program command to a factory word changes nothing and drives `wr_err` high for exactly the cycle after the strobe.
- R8: A lock command (opcode 2) locks the user half when data bit 1 is 0. It leaves the lock state unchanged when data bit 1 is 1. The address and all other data bits are ignored.
- R9: Once locked, program commands to user words have no effect, and the lock cannot be undone except by a cold reset.
- R10: A status command (opcode 3) returns, one cycle later, 0xFFFF with bit 1 cleared when the user half is locked and set when it is unlocked. It works regardless of `id_mode`.
- R11: A warm reset alone clears `rd_valid` and `wr_err` and restores the factory words. It keeps the user words and the lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold (power-on) reset, active low, asynchronous |
| rst_n | input | 1 | Warm reset, active low, asynchronous |
| id_mode | input | 1 | Identification-read mode flag; enables register reads |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 0 read, 1 program, 2 lock, 3 status |
| cmd_addr | input | 12 | Word address |
| cmd_data | input | 16 | Program data or lock control word |
| rd_data | output | 16 | Read or status result |
| rd_valid | output | 1 | `rd_data` holds a result this cycle |
| wr_err | output | 1 | One-cycle pulse after a program aimed at the factory half |

## Verification
The bench sweeps every address from 0x000 to 0x1FF, plus several with high bits set, and repeats the sweep after each state change. This catches an off-by-one window (0x080 or 0x089 accepted), a decoder that ignores the upper bits, and a swapped half. User-word patterns are chosen so that a design that overwrites instead of ANDing shows bits returning to 1. Lock commands are sent with bit 1 set but every other bit clear, and with bit 1 clear but other bits set, to expose a design that decodes the wrong bit. Both resets are exercised in turn: a design that clears user data or the lock on a warm reset, or keeps them through a cold reset, returns the wrong words.

// File: rtl/otp_sec_pkg.sv
package otp_sec_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_PROG   = 2'd1,
        OP_LOCK   = 2'd2,
        OP_STATUS = 2'd3
    } otp_op_e;

endpackage

// File: rtl/otp_sec_decode.sv
module otp_sec_decode #(
    parameter int ADDR_W = 12,
    parameter int NUM_WORDS = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h081,
    localparam int IDX_W = $clog2(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_user,
    output logic [IDX_W-2:0]  slot
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset  = addr - BASE_ADDR;
        hit     = (addr >= BASE_ADDR) && (offset[ADDR_W-1:IDX_W] == '0);
        is_user = offset[IDX_W-1];
        slot    = offset[IDX_W-2:0];
    end

endmodule

// File: rtl/otp_sec_factory_bank.sv
module otp_sec_factory_bank #(
    parameter int WORD_W = 16,
    parameter int DEPTH = 4,
    parameter logic [WORD_W*DEPTH-1:0] INIT = '0,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_word
);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] words;
    } fac_st_t;

    fac_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_word = st_q.words[rd_slot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                st_q.words[k] <= INIT[k*WORD_W +: WORD_W];
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/otp_sec_user_bank.sv
module otp_sec_user_bank #(
    parameter int WORD_W = 16,
    parameter int DEPTH = 4,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              prog_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              lock_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              locked
);

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] words;
        logic                         locked;
    } usr_st_t;

    usr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prog_en && !st_q.locked) begin
            st_d.words[slot] = st_q.words[slot] & prog_data;
        end
        if (lock_en) begin
            st_d.locked = 1'b1;
        end
        rd_word = st_q.words[slot];
        locked  = st_q.locked;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.words  <= '1;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: stored bits never return from 0 to 1
    a_r6_bits_only_clear: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> ((st_q.words & ~$past(st_q.words)) == '0));

    // R9: a locked bank keeps its words and its lock
    a_r9_locked_frozen: assert property (@(posedge clk) disable iff (!por_n)
        st_q.locked |=> (st_q.locked && $stable(st_q.words)));

endmodule

// File: rtl/otp_sec_regbank.sv
module otp_sec_regbank
    import otp_sec_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h081,
    parameter logic [WORD_W*NUM_WORDS/2-1:0] FACTORY_INIT = 64'h7a3c_e519_0b6d_42f8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              id_mode,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              wr_err
);

    localparam int HALF   = NUM_WORDS / 2;
    localparam int IDX_W  = $clog2(NUM_WORDS);
    localparam int SLOT_W = IDX_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] rd_data;
        logic              rd_valid;
        logic              wr_err;
    } port_st_t;

    otp_op_e           op;
    logic              hit, is_user, locked;
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] fac_word, usr_word;
    logic              prog_user, lock_req;
    port_st_t          out_d, out_q;

    assign op = otp_op_e'(cmd_op);

    otp_sec_decode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .BASE_ADDR(BASE_ADDR)
    ) u_decode (
        .addr(cmd_addr), .hit(hit), .is_user(is_user), .slot(slot)
    );

    otp_sec_factory_bank #(
        .WORD_W(WORD_W), .DEPTH(HALF), .INIT(FACTORY_INIT)
    ) u_factory (
        .clk(clk), .rst_n(rst_n), .rd_slot(slot), .rd_word(fac_word)
    );

    assign prog_user = cmd_valid && (op == OP_PROG) && hit && is_user;
    assign lock_req  = cmd_valid && (op == OP_LOCK) && !cmd_data[1];

    otp_sec_user_bank #(
        .WORD_W(WORD_W), .DEPTH(HALF)
    ) u_user (
        .clk(clk), .por_n(por_n), .prog_en(prog_user), .slot(slot),
        .prog_data(cmd_data), .lock_en(lock_req),
        .rd_word(usr_word), .locked(locked)
    );

    always_comb begin
        out_d          = out_q;
        out_d.rd_valid = cmd_valid && ((op == OP_READ) || (op == OP_STATUS));
        out_d.wr_err   = cmd_valid && (op == OP_PROG) && hit && !is_user;
        if (cmd_valid && (op == OP_STATUS)) begin
            out_d.rd_data    = '1;
            out_d.rd_data[1] = ~locked;
        end else if (cmd_valid && (op == OP_READ)) begin
            if (id_mode && hit) begin
                out_d.rd_data = is_user ? usr_word : fac_word;
            end else begin
                out_d.rd_data = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.rd_data  <= '1;
            out_q.rd_valid <= 1'b0;
            out_q.wr_err   <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data  = out_q.rd_data;
    assign rd_valid = out_q.rd_valid;
    assign wr_err   = out_q.wr_err;

    // R3: a result appears only after a read or status strobe
    a_r3_valid_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        rd_valid |-> ($past(cmd_valid) && ($past(cmd_op) == OP_READ || $past(cmd_op) == OP_STATUS)));

    // R4: reads outside identification mode expose nothing
    a_r4_no_read_outside_id: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (rd_valid && $past(cmd_op) == OP_READ && !$past(id_mode)) |-> (rd_data == '1));

    // R5: programs to unmapped addresses raise no error
    a_r5_unmapped_no_err: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (cmd_valid && op == OP_PROG && !hit) |=> !wr_err);

    // R7: the error pulse follows only a factory-half program
    a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wr_err |-> ($past(cmd_valid) && $past(cmd_op) == OP_PROG && $past(hit) && !$past(is_user)));

endmodule

// File: tb/otp_sec_regbank_test.sv
module otp_sec_regbank_test;

    localparam logic [63:0] FINIT = 64'h7a3c_e519_0b6d_42f8;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0, id_mode = 1'b0, cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [11:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid, wr_err;

    int total = 0, bad = 0, cycles = 0;
    logic [15:0] m_fac [4];
    logic [15:0] m_usr [4];
    logic        m_lock;
    logic [15:0] g_data;
    logic        g_valid, g_err;

    otp_sec_regbank #(.FACTORY_INIT(FINIT)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .id_mode(id_mode),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_data(rd_data), .rd_valid(rd_valid), .wr_err(wr_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input logic [11:0] a, input logic id);
        if (!id || a < 12'h081 || a > 12'h088) return 16'hFFFF;
        if (a <= 12'h084) return m_fac[a - 12'h081];
        return m_usr[a - 12'h085];
    endfunction

    task automatic cmd(input logic [1:0] op, input logic [11:0] a, input logic [15:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        g_data = rd_data; g_valid = rd_valid; g_err = wr_err;
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        @(posedge clk); #1;
        g_data = rd_data; g_valid = rd_valid; g_err = wr_err;
    endtask

    task automatic sweep(input string tag);
        id_mode = 1'b1;
        for (int a = 0; a < 512; a++) begin
            cmd(2'd0, 12'(a), 16'h0);
            check({tag, " R3 valid"}, {15'd0, g_valid}, 16'd1);
            check({tag, " R1/R2/R5 data"}, g_data, model_read(12'(a), 1'b1));
        end
        foreach (m_fac[i]) begin
            cmd(2'd0, 12'h800 | 12'(12'h081 + i), 16'h0);
            check({tag, " R5 high bits"}, g_data, 16'hFFFF);
        end
    endtask

    task automatic status_check(input string tag);
        cmd(2'd3, 12'h000, 16'h0);
        check({tag, " R10 valid"}, {15'd0, g_valid}, 16'd1);
        check({tag, " R10 status"}, g_data, m_lock ? 16'hFFFD : 16'hFFFF);
    endtask

    task automatic cold_model();
        foreach (m_fac[i]) m_fac[i] = FINIT[i*16 +: 16];
        foreach (m_usr[i]) m_usr[i] = 16'hFFFF;
        m_lock = 1'b0;
    endtask

    initial begin
        cold_model();
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset rd_valid", {15'd0, rd_valid}, 16'd0);
        check("R11 reset wr_err", {15'd0, wr_err}, 16'd0);
        por_n = 1'b1; rst_n = 1'b1;
        idle();
        check("R3 idle no valid", {15'd0, g_valid}, 16'd0);

        sweep("initial");
        status_check("R2 unlocked");

        id_mode = 1'b0;
        for (int a = 16'h080; a <= 16'h089; a++) begin
            cmd(2'd0, 12'(a), 16'h0);
            check("R4 no id read", g_data, 16'hFFFF);
        end
        status_check("R10 no id");

        foreach (m_usr[i]) begin
            logic [15:0] p1, p2;
            p1 = 16'hF0F0 ^ 16'(i * 16'h1111);
            p2 = 16'h3C3C | 16'(i);
            cmd(2'd1, 12'(12'h085 + i), p1); m_usr[i] &= p1;
            check("R6 no err", {15'd0, g_err}, 16'd0);
            cmd(2'd1, 12'(12'h085 + i), p2); m_usr[i] &= p2;
            cmd(2'd1, 12'(12'h085 + i), 16'hFFFF);
        end
        sweep("after program R6");

        foreach (m_fac[i]) begin
            cmd(2'd1, 12'(12'h081 + i), 16'h0000);
            check("R7 err pulse", {15'd0, g_err}, 16'd1);
            idle();
            check("R7 err one cycle", {15'd0, g_err}, 16'd0);
        end
        cmd(2'd1, 12'h080, 16'h0000);
        check("R5 no err 080", {15'd0, g_err}, 16'd0);
        cmd(2'd1, 12'h089, 16'h0000);
        check("R5 no err 089", {15'd0, g_err}, 16'd0);
        cmd(2'd1, 12'h885, 16'h0000);
        check("R5 no err 885", {15'd0, g_err}, 16'd0);
        sweep("after bad writes R5 R7");

        cmd(2'd2, 12'h080, 16'h0002);
        status_check("R8 bit1 set keeps unlocked");
        cmd(2'd1, 12'h086, 16'h00FF); m_usr[1] &= 16'h00FF;
        cmd(2'd2, 12'h3A7, 16'hFFFD); m_lock = 1'b1;
        status_check("R8 locked");
        cmd(2'd2, 12'h080, 16'hFFFF);
        status_check("R9 lock sticks");

        foreach (m_usr[i]) cmd(2'd1, 12'(12'h085 + i), 16'h0000);
        sweep("after locked writes R9");

        rst_n = 1'b0;
        #1;
        check("R11 warm rd_valid", {15'd0, rd_valid}, 16'd0);
        check("R11 warm wr_err", {15'd0, wr_err}, 16'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        status_check("R11 lock kept");
        sweep("after warm reset R11");

        por_n = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        por_n = 1'b1; rst_n = 1'b1;
        cold_model();
        status_check("R2 cold unlocked");
        sweep("after cold reset R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule